// File: doc/BRIEF.md
# Banked Interrupt Identity Selector

This block collects interrupt vectors from a set of engines into two banks and lets software service them one source at a time. Each engine raises a 16-bit vector with a one-cycle event strobe. Bits that pass the engine's enable and mask fields are ORed into a per-source held vector, and the source's bit is set in its bank's pending dword. A master word shows which banks have any pending bit, and a single interrupt line is high while either bank is pending.

To service a source, software writes a one-hot value into the bank's selector. After a fixed latency the bank's identity register shows a valid flag, together with the class (the bank number), the instance (the bit index) and the vector that was gathered. Software acknowledges the identity by writing the valid bit back. Only after that acknowledge does a write of that bit to the pending dword clear it. Reading a pending dword locks it. Events that arrive during the lock are parked in a shadow register, and they are merged when the dword is next written.

Events are accepted in every cycle: the event inputs carry no ready signal and no back-pressure, so a strobe is never stalled or dropped. The register port is a plain single-cycle read/write port. Read data is combinational from the address, and only a strobed read of a pending dword has a side effect.

Top module: `irqb_top`

## Requirements
- R1: After reset, every mask register reads 0xFFFFFFFF, every enable register reads 0, and both pending dwords, the master word (address 0) and `irq` are zero.
- R2: An event bit is accepted only where its enable bit is 1 and its mask bit is 0. For bank b, pair p, the enable register is at 8+b*NPAIR+p and the mask register is at 8+2*NPAIR+b*NPAIR+p. The even source of the pair uses bits 15:0 and the odd source uses bits 31:16.
- R3: Accepted bits are ORed into the source's held vector and set bit s of the bank's dword (address 1 for bank 0, address 2 for bank 1). Master bit b is the OR of dword b, and `irq` is high while any master bit is set.
- R4: A one-hot selector write (address 3 or 4) makes the identity register (address 5 or 6) read valid exactly LAT cycles later. Until then the register reads 0.
- R5: The identity word holds valid in bit 31, class (the bank number) in bits 23:20, instance in bits 19:16 and the vector in bits 15:0. Capturing the vector empties the source's held vector.
- R6: A write with bit 31 set to a valid identity clears it and marks the source as serviced.
- R7: A dword write clears only those written bits whose source is serviced and holds no new vector. Writes to the other bits are ignored.
- R8: A strobed read of a dword locks it. Events during the lock do not appear in the dword or the master word. Any write to that dword unlocks it and merges the parked events.
- R9: An event for the selected source that lands in the identity capture cycle is not reported in that identity. It is kept and reported by the next identity.
- R10: A selector write that is not one-hot within NSRC bits, or that comes while an identity is pending or valid, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (locks a dword) |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| ev_valid | input | 2*NSRC | Event strobe per source, bank-major |
| ev_vec | input | 2*NSRC*16 | Event vector per source |
| irq | output | 1 | Any bank pending |

## Verification
The contested cycle is the identity capture. In that edge the bank copies the selected source's held vector and empties it, while the same source's strobe may also be ORing new bits into that vector. The bench counts the selector latency and places a second event exactly on the capture edge. It then requires that the first identity carries only the first vector, that the clear after acknowledge leaves the bit set through the shadow merge, and that a second service returns exactly the second vector.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int VW = 16;
  localparam logic [AW-1:0] A_MASTER = 6'd0;
  localparam logic [AW-1:0] A_DW0    = 6'd1;
  localparam logic [AW-1:0] A_DW1    = 6'd2;
  localparam logic [AW-1:0] A_SEL0   = 6'd3;
  localparam logic [AW-1:0] A_SEL1   = 6'd4;
  localparam logic [AW-1:0] A_ID0    = 6'd5;
  localparam logic [AW-1:0] A_ID1    = 6'd6;
  localparam int A_CFG = 8;

  function automatic logic [DW-1:0] ident_word(logic [3:0] cls, logic [3:0] inst,
                                               logic [VW-1:0] vec);
    return {1'b1, 7'b0, cls, inst, vec};
  endfunction
endpackage

// File: rtl/irqb_cfg.sv
module irqb_cfg
  import irqb_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  output logic [2*NSRC/2*DW-1:0] en_flat,
  output logic [2*NSRC/2*DW-1:0] mk_flat,
  output logic [2*NSRC*VW-1:0]   gate
);
  localparam int NPAIR = NSRC / 2;
  localparam int NREG  = 2 * NPAIR;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [DW-1:0] en_q, mk_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q <= '0;
        mk_q <= '1;
      end else if (wr) begin
        if (addr == AW'(A_CFG + k))        en_q <= wdata;
        if (addr == AW'(A_CFG + NREG + k)) mk_q <= wdata;
      end
    end
    assign en_flat[k*DW +: DW] = en_q;
    assign mk_flat[k*DW +: DW] = mk_q;
    for (genvar h = 0; h < 2; h++) begin : g_half
      assign gate[(2*k+h)*VW +: VW] = en_q[h*VW +: VW] & ~mk_q[h*VW +: VW];
    end
  end
endmodule

// File: rtl/irqb_bank.sv
module irqb_bank
  import irqb_pkg::*;
#(
  parameter int         NSRC = 4,
  parameter int         LAT  = 4,
  parameter logic [3:0] CLS  = 4'd0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC*VW-1:0]   ev_bits,
  input  logic                 dw_rd,
  input  logic                 dw_wr,
  input  logic                 sel_wr,
  input  logic                 id_wr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        dw_word,
  output logic [DW-1:0]        id_word,
  output logic                 pend
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic [VW-1:0]   acc_q [NSRC];
  logic [NSRC-1:0] dw_q, sh_q, svc_q, sel_q, hit, acc_nz, clr;
  logic            locked_q, busy_q, idv_q, capture, sel_ok, ack;
  logic [CW-1:0]   cnt_q;
  logic [VW-1:0]   idvec_q, cap_vec;
  logic [3:0]      idinst_q, cap_inst;

  assign capture = busy_q && (cnt_q == '0);
  assign sel_ok  = sel_wr && !busy_q && !idv_q && $onehot(wdata[NSRC-1:0])
                   && ((wdata >> NSRC) == '0);
  assign ack     = id_wr && wdata[DW-1] && idv_q;
  assign clr     = wdata[NSRC-1:0] & svc_q & ~acc_nz & {NSRC{dw_wr}};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign hit[s]    = |ev_bits[s*VW +: VW];
    assign acc_nz[s] = |acc_q[s];
    always_ff @(posedge clk) begin
      if (!rst_n)                 acc_q[s] <= '0;
      else if (capture && sel_q[s]) acc_q[s] <= ev_bits[s*VW +: VW];
      else                        acc_q[s] <= acc_q[s] | ev_bits[s*VW +: VW];
    end
  end

  always_comb begin
    cap_vec  = '0;
    cap_inst = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (sel_q[s]) begin
        cap_vec  = cap_vec | acc_q[s];
        cap_inst = cap_inst | 4'(s);
      end
    end
  end

  // pending dword, shadow and lock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dw_q     <= '0;
      sh_q     <= '0;
      locked_q <= 1'b0;
      svc_q    <= '0;
    end else begin
      if (dw_wr) begin
        dw_q     <= (dw_q & ~clr) | sh_q | hit;
        sh_q     <= '0;
        locked_q <= 1'b0;
      end else begin
        if (locked_q) sh_q <= sh_q | hit;
        else          dw_q <= dw_q | hit;
        if (dw_rd)    locked_q <= 1'b1;
      end
      svc_q <= (svc_q & ~clr) | (ack ? sel_q : '0);
    end
  end

  // selector and identity
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      idv_q    <= 1'b0;
      idvec_q  <= '0;
      idinst_q <= '0;
    end else begin
      if (sel_ok) begin
        sel_q  <= wdata[NSRC-1:0];
        busy_q <= 1'b1;
        cnt_q  <= CW'(LAT - 1);
      end else if (capture) begin
        busy_q   <= 1'b0;
        idv_q    <= 1'b1;
        idvec_q  <= cap_vec;
        idinst_q <= cap_inst;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (ack) idv_q <= 1'b0;
    end
  end

  assign dw_word = {{(DW-NSRC){1'b0}}, dw_q};
  assign id_word = idv_q ? ident_word(CLS, idinst_q, idvec_q) : '0;
  assign pend    = |dw_q;

  assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !dw_wr) |=> ((dw_q & ~$past(dw_q)) == '0));
  assert_clear_serviced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dw_wr |=> (($past(dw_q) & ~dw_q & ~$past(svc_q)) == '0));
  assert_valid_after_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idv_q) |-> $past(busy_q));
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !idv_q);
  assert_sel_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && (busy_q || idv_q)) |=> $stable(sel_q));
endmodule

// File: rtl/irqb_top.sv
module irqb_top
  import irqb_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int LAT  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [5:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic [2*NSRC-1:0]      ev_valid,
  input  logic [2*NSRC*16-1:0]   ev_vec,
  output logic                   irq
);
  localparam int NPAIR = NSRC / 2;
  localparam int NREG  = 2 * NPAIR;

  logic [NREG*DW-1:0]      en_flat, mk_flat;
  logic [2*NSRC*VW-1:0]    gate, ev_bits;
  logic [DW-1:0]           dw_word [2];
  logic [DW-1:0]           id_word [2];
  logic [1:0]              pend;

  irqb_cfg #(.NSRC(NSRC)) i_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .en_flat(en_flat), .mk_flat(mk_flat), .gate(gate)
  );

  for (genvar g = 0; g < 2*NSRC; g++) begin : g_ev
    assign ev_bits[g*VW +: VW] = ev_valid[g] ? (ev_vec[g*VW +: VW] & gate[g*VW +: VW]) : '0;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    irqb_bank #(.NSRC(NSRC), .LAT(LAT), .CLS(4'(b))) i_bank (
      .clk(clk), .rst_n(rst_n),
      .ev_bits(ev_bits[b*NSRC*VW +: NSRC*VW]),
      .dw_rd(reg_rd && !reg_wr && reg_addr == AW'(A_DW0 + b)),
      .dw_wr(reg_wr && reg_addr == AW'(A_DW0 + b)),
      .sel_wr(reg_wr && reg_addr == AW'(A_SEL0 + b)),
      .id_wr(reg_wr && reg_addr == AW'(A_ID0 + b)),
      .wdata(reg_wdata),
      .dw_word(dw_word[b]), .id_word(id_word[b]), .pend(pend[b])
    );
  end

  assign irq = |pend;

  always_comb begin
    int idx;
    idx = int'(reg_addr) - A_CFG;
    reg_rdata = '0;
    case (reg_addr)
      A_MASTER: reg_rdata = {30'b0, pend};
      A_DW0:    reg_rdata = dw_word[0];
      A_DW1:    reg_rdata = dw_word[1];
      A_ID0:    reg_rdata = id_word[0];
      A_ID1:    reg_rdata = id_word[1];
      default: begin
        if (idx >= 0 && idx < NREG)           reg_rdata = en_flat[idx*DW +: DW];
        else if (idx >= NREG && idx < 2*NREG) reg_rdata = mk_flat[(idx-NREG)*DW +: DW];
      end
    endcase
  end

  assert_irq_follows_dword_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((dw_word[0] | dw_word[1]) != '0) |-> irq);
endmodule

// File: tb/test_irqb_top.sv
module test_irqb_top;
  localparam int NSRC = 4;
  localparam int LAT  = 4;
  localparam int NREG = NSRC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [2*NSRC-1:0] ev_valid = '0;
  logic [2*NSRC*16-1:0] ev_vec = '0;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irqb_top #(.NSRC(NSRC), .LAT(LAT)) i_irqb_top (.*);

  // b, s, enable half, mask half, event vector, expected vector
  localparam logic [71:0] TBL [6] = '{
    {4'd0, 4'd0, 16'hFFFF, 16'h0000, 16'h0001, 16'h0001},
    {4'd0, 4'd1, 16'h00FF, 16'h0000, 16'h0F0F, 16'h000F},
    {4'd1, 4'd2, 16'hFFFF, 16'hFF00, 16'h1234, 16'h0034},
    {4'd1, 4'd3, 16'hFFFF, 16'h0000, 16'h8000, 16'h8000},
    {4'd0, 4'd2, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000},
    {4'd1, 4'd0, 16'hFFFF, 16'hFFFF, 16'h00AA, 16'h0000}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rdlock(logic [5:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(logic [5:0] a, output logic [31:0] v);
    reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic ev(int g, logic [15:0] v);
    @(negedge clk); ev_valid[g] = 1'b1; ev_vec[g*16 +: 16] = v;
    @(negedge clk); ev_valid[g] = 1'b0; ev_vec[g*16 +: 16] = '0;
  endtask

  task automatic service(int b, int s, output logic [31:0] id);
    logic [31:0] t;
    rdlock(6'(1 + b), t);
    wr(6'(3 + b), 32'(1) << s);
    id = '0;
    for (int n = 0; n < 20 && !id[31]; n++) begin
      peek(6'(5 + b), id);
      if (!id[31]) @(negedge clk);
    end
    wr(6'(5 + b), 32'h8000_0000);
    wr(6'(1 + b), 32'(1) << s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, id;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int k = 0; k < NREG; k++) begin
      peek(6'(8 + k), v);        chk("R1 enable reset", v, 32'h0);
      peek(6'(8 + NREG + k), v); chk("R1 mask reset", v, 32'hFFFF_FFFF);
    end
    peek(6'd0, v); chk("R1 master reset", v, 32'h0);
    peek(6'd1, v); chk("R1 dw0 reset", v, 32'h0);
    peek(6'd2, v); chk("R1 dw1 reset", v, 32'h0);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);

    // table: R2 gating, R3 pending, R5 identity format, R7 clear
    foreach (TBL[i]) begin
      int b, s, k;
      logic [15:0] en, mk, vec, exp;
      b = int'(TBL[i][71:68]); s = int'(TBL[i][67:64]);
      en = TBL[i][63:48]; mk = TBL[i][47:32]; vec = TBL[i][31:16]; exp = TBL[i][15:0];
      k = b*(NSRC/2) + s/2;
      wr(6'(8 + k), s[0] ? {en, 16'h0} : {16'h0, en});
      wr(6'(8 + NREG + k), s[0] ? {mk, 16'hFFFF} : {16'hFFFF, mk});
      ev(b*NSRC + s, vec);
      peek(6'd0, v); chk("R2 R3 master after event", v, exp != 0 ? (32'(1) << b) : 32'h0);
      chk("R3 irq after event", {31'b0, irq}, {31'b0, exp != 0});
      if (exp != 0) begin
        service(b, s, id);
        chk("R5 identity word", id, {1'b1, 7'b0, 4'(b), 4'(s), exp});
        peek(6'(1 + b), v); chk("R7 dword cleared after service", v, 32'h0);
      end
      wr(6'(8 + k), 32'h0);
      wr(6'(8 + NREG + k), 32'hFFFF_FFFF);
    end

    for (int k = 0; k < NREG; k++) begin
      wr(6'(8 + k), 32'hFFFF_FFFF);
      wr(6'(8 + NREG + k), 32'h0);
    end

    // R4 latency: not valid for LAT cycles, valid after
    ev(1, 16'h0042);
    wr(6'd3, 32'h2);
    for (int j = 0; j < LAT; j++) begin
      peek(6'd5, v); chk("R4 identity not yet valid", v, 32'h0);
      @(negedge clk);
    end
    peek(6'd5, v); chk("R4 identity valid at LAT", v, {1'b1, 7'b0, 4'd0, 4'd1, 16'h0042});
    // R10 selector while identity valid is ignored
    wr(6'd3, 32'h1);
    repeat (LAT + 1) @(negedge clk);
    peek(6'd5, v); chk("R10 busy selector ignored", v, {1'b1, 7'b0, 4'd0, 4'd1, 16'h0042});
    wr(6'd5, 32'h8000_0000);
    peek(6'd5, v); chk("R6 acknowledge clears valid", v, 32'h0);
    wr(6'd1, 32'h2);
    peek(6'd1, v); chk("R6 serviced bit cleared", v, 32'h0);

    // R10 non one-hot selector ignored
    wr(6'd3, 32'h3);
    repeat (LAT + 2) @(negedge clk);
    peek(6'd5, v); chk("R10 non one-hot ignored", v, 32'h0);

    // R7 clear of unserviced bit ignored
    ev(0, 16'h0004);
    rdlock(6'd1, v); chk("R7 dword read", v, 32'h1);
    wr(6'd1, 32'h1);
    peek(6'd1, v); chk("R7 unserviced clear ignored", v, 32'h1);
    service(0, 0, id);
    chk("R7 identity after ignored clear", id, {1'b1, 7'b0, 4'd0, 4'd0, 16'h0004});
    peek(6'd1, v); chk("R7 cleared after service", v, 32'h0);

    // R8 lock and shadow merge
    ev(NSRC + 1, 16'h0001);
    rdlock(6'd2, v); chk("R8 dword1 read", v, 32'h2);
    ev(NSRC + 0, 16'h0010);
    peek(6'd2, v); chk("R8 locked dword unchanged", v, 32'h2);
    peek(6'd0, v); chk("R8 master during lock", v, 32'h2);
    wr(6'd2, 32'h0);
    peek(6'd2, v); chk("R8 shadow merged on write", v, 32'h3);
    service(1, 1, id);
    service(1, 0, id);
    chk("R8 parked event identity", id, {1'b1, 7'b0, 4'd1, 4'd0, 16'h0010});
    peek(6'd2, v); chk("R8 dword1 empty", v, 32'h0);

    // R9 event in the capture cycle
    ev(2, 16'h0011);
    rdlock(6'd1, v);
    wr(6'd3, 32'h4);
    repeat (LAT - 1) @(negedge clk);
    ev_valid[2] = 1'b1; ev_vec[2*16 +: 16] = 16'h0200;
    @(negedge clk);
    ev_valid[2] = 1'b0; ev_vec[2*16 +: 16] = '0;
    peek(6'd5, v); chk("R9 first identity excludes late event", v, {1'b1, 7'b0, 4'd0, 4'd2, 16'h0011});
    wr(6'd5, 32'h8000_0000);
    wr(6'd1, 32'h4);
    peek(6'd1, v); chk("R9 bit stays pending", v, 32'h4);
    service(0, 2, id);
    chk("R9 second identity", id, {1'b1, 7'b0, 4'd0, 4'd2, 16'h0200});
    peek(6'd1, v); chk("R9 dword empty", v, 32'h0);
    chk("R3 irq low when empty", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule